// File: doc/BRIEF.md
# Denied-Access Error Capture Unit

This unit sits behind an access checker and handles every transaction the checker has refused. For each refused access it completes the bus transaction with either an ERROR or an OK response. A refused read always returns zero data. A refused write never reaches the target. The checker decides, per access, whether the refusal should produce a bus error, an interrupt, both or neither. This unit acts on that decision.

The unit also records the first refusal that asks for a report. It keeps that refusal in two software-visible registers: a cause word and a word-granular fault address. The interrupt line follows the pending-interrupt flag as a level. Once a bus-error flag or an interrupt flag is pending, both registers are frozen and no new interrupt can start. Software reads the registers through a small register port and rearms the unit by clearing both flags. If a software write and a refusal arrive in the same cycle, the software write takes effect and the refusal is not recorded.

Top module: `blocked_err_capture`

## Requirements
- R1: After reset the cause word and the fault address read as zero, `irq` is low and `rspValid` is low.
- R2: One clock edge after `denyValid` is sampled high, `rspValid` is high for exactly one cycle. While `rspValid` is high, `rspRdata` is zero, for reads and writes alike.
- R3: `rspErr` is high in the response cycle exactly when `wantBusErr` was high with the refused access.
- R4: Capture happens when no flag is pending, no register write occurs in the same cycle, and `wantBusErr` or `wantIrq` is set. On capture the cause word takes the WID in bits [WID_W-1:0]. Bit 8 takes the value of not-`denyWrite` (read flag) and bit 9 takes `denyWrite` (write flag).
- R5: On capture the fault address register (`regSel`=1) takes the byte address shifted right by two, that is `denyAddr[ADDR_W-1:2]`, in bits [ADDR_W-3:0].
- R6: On capture with `wantIrq` set, cause bit 31 (interrupt pending) is set, and `irq` is high from the next edge for as long as that bit stays set.
- R7: On capture with `wantBusErr` set, cause bit 30 (bus error pending) is set.
- R8: While bit 30 or bit 31 is set, refused accesses leave both registers unchanged and do not raise `irq`.
- R9: A refused access with neither `wantBusErr` nor `wantIrq` leaves both registers and `irq` unchanged and completes with `rspErr` low.
- R10: A register write with `regSel`=0 clears bit 30 when `regWflags[0]` is 0 and clears bit 31 when `regWflags[1]` is 0. A flag written as 1 keeps its current value and is never set by software. A write with `regSel`=1 changes nothing.
- R11: When `regWe` and `denyValid` are high in the same cycle, the write is applied and the refused access records nothing. It still receives its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| denyValid | input | 1 | A refused access is presented this cycle |
| denyAddr | input | ADDR_W-2 | Byte address bits [ADDR_W-1:2] of the refused access |
| denyWid | input | WID_W | World identifier of the requester |
| denyWrite | input | 1 | 1 for a write, 0 for a read |
| wantBusErr | input | 1 | Checker asks for a bus error |
| wantIrq | input | 1 | Checker asks for an interrupt |
| rspValid | output | 1 | Response to a refused access |
| rspErr | output | 1 | 1 = ERROR response, 0 = OK |
| rspRdata | output | DATA_W | Read data returned (always zero) |
| irq | output | 1 | Interrupt level |
| regSel | input | 1 | 0 = cause word, 1 = fault address |
| regWe | input | 1 | Register write strobe |
| regWflags | input | 2 | Write value for {interrupt, bus error} flags |
| regRdata | output | 32 | Combinational read of the selected register |

## Verification
Every result of a refused access is due one clock edge after the access is sampled. This covers the response, the recorded cause and address, the set flags and the interrupt level. A register clear also takes effect on that edge. The bench drives inputs on the falling edge and withdraws them on the next falling edge, so it reads the registered outputs half a period after the edge that produced them. Register contents are read combinationally through `regSel` after a short settle, with no clock edge in between. This lets the bench observe a frozen state before the next stimulus can disturb it.

// File: rtl/bec_pkg.sv
package bec_pkg;
  // Cause word layout; software decodes these positions.
  localparam int unsigned CAUSE_W   = 32;
  localparam int unsigned RD_BIT    = 8;
  localparam int unsigned WR_BIT    = 9;
  localparam int unsigned BE_BIT    = 30;
  localparam int unsigned IP_BIT    = 31;
  localparam int unsigned MAX_WID_W = 8;

  // Strobes from control into the datapath.
  typedef struct packed {
    logic capture;
    logic setBe;
    logic setIp;
    logic clrBe;
    logic clrIp;
    logic rspFire;
    logic rspErr;
  } capStrobe_t;
endpackage

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
(
  input  logic       denyValid,
  input  logic       wantBusErr,
  input  logic       wantIrq,
  input  logic       lockedQ,
  input  logic       regWe,
  input  logic       regSel,
  input  logic [1:0] regWflags,
  output capStrobe_t strobe
);
  logic reportable;
  logic causeWrite;

  always_comb begin
    reportable     = wantBusErr | wantIrq;
    causeWrite     = regWe & ~regSel;
    // Any software write in the same cycle suppresses recording.
    strobe.capture = denyValid & ~lockedQ & ~regWe & reportable;
    strobe.setBe   = strobe.capture & wantBusErr;
    strobe.setIp   = strobe.capture & wantIrq;
    strobe.clrBe   = causeWrite & ~regWflags[0];
    strobe.clrIp   = causeWrite & ~regWflags[1];
    strobe.rspFire = denyValid;
    strobe.rspErr  = denyValid & wantBusErr;
  end
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WID_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          strobe,
  input  logic [ADDR_W-1:2]   denyAddr,
  input  logic [WID_W-1:0]    denyWid,
  input  logic                denyWrite,
  input  logic                regSel,
  output logic                lockedQ,
  output logic                beQ,
  output logic                ipQ,
  output logic [CAUSE_W-1:0]  causeWord,
  output logic [31:0]         addrWord,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [31:0]         regRdata
);
  localparam int unsigned EA_W = ADDR_W - 2;

  logic [WID_W-1:0] widQ;
  logic             rdQ;
  logic             wrQ;
  logic [EA_W-1:0]  eaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widQ     <= '0;
      rdQ      <= 1'b0;
      wrQ      <= 1'b0;
      eaQ      <= '0;
      beQ      <= 1'b0;
      ipQ      <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        widQ <= denyWid;
        rdQ  <= ~denyWrite;
        wrQ  <= denyWrite;
        eaQ  <= denyAddr;
      end
      if (strobe.setBe)      beQ <= 1'b1;
      else if (strobe.clrBe) beQ <= 1'b0;
      if (strobe.setIp)      ipQ <= 1'b1;
      else if (strobe.clrIp) ipQ <= 1'b0;
      rspValid <= strobe.rspFire;
      rspErr   <= strobe.rspErr;
    end
  end

  assign lockedQ  = beQ | ipQ;
  assign rspRdata = '0;

  always_comb begin
    causeWord               = '0;
    causeWord[WID_W-1:0]    = widQ;
    causeWord[RD_BIT]       = rdQ;
    causeWord[WR_BIT]       = wrQ;
    causeWord[BE_BIT]       = beQ;
    causeWord[IP_BIT]       = ipQ;
    addrWord                = '0;
    addrWord[EA_W-1:0]      = eaQ;
    regRdata                = regSel ? addrWord : causeWord;
  end
endmodule

// File: rtl/blocked_err_capture.sv
module blocked_err_capture
  import bec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WID_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              denyValid,
  input  logic [ADDR_W-1:2] denyAddr,
  input  logic [WID_W-1:0]  denyWid,
  input  logic              denyWrite,
  input  logic              wantBusErr,
  input  logic              wantIrq,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              irq,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [1:0]        regWflags,
  output logic [31:0]       regRdata
);
  capStrobe_t         strobe;
  logic               lockedQ;
  logic               beFlag;
  logic               ipFlag;
  logic [CAUSE_W-1:0] causeWord;
  logic [31:0]        addrWord;

  if (WID_W > MAX_WID_W || ADDR_W > 34 || ADDR_W < 4) begin : g_badParam
    initial $error("blocked_err_capture: parameter out of range");
  end

  bec_ctrl u_ctrl (
    .denyValid (denyValid),
    .wantBusErr(wantBusErr),
    .wantIrq   (wantIrq),
    .lockedQ   (lockedQ),
    .regWe     (regWe),
    .regSel    (regSel),
    .regWflags (regWflags),
    .strobe    (strobe)
  );

  bec_datapath #(.ADDR_W(ADDR_W), .WID_W(WID_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .denyAddr (denyAddr),
    .denyWid  (denyWid),
    .denyWrite(denyWrite),
    .regSel   (regSel),
    .lockedQ  (lockedQ),
    .beQ      (beFlag),
    .ipQ      (ipFlag),
    .causeWord(causeWord),
    .addrWord (addrWord),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspRdata (rspRdata),
    .regRdata (regRdata)
  );

  assign irq = ipFlag;
endmodule

// File: rtl/blocked_err_capture_chk.sv
module blocked_err_capture_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WID_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              denyValid,
  input logic [ADDR_W-1:2] denyAddr,
  input logic              wantBusErr,
  input logic              wantIrq,
  input logic              regWe,
  input logic              rspValid,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspRdata,
  input logic              irq,
  input logic              beFlag,
  input logic              ipFlag,
  input logic [31:0]       causeWord,
  input logic [31:0]       addrWord
);
  localparam int unsigned EA_W = ADDR_W - 2;

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    denyValid |=> rspValid);

  // R2
  rsp_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspRdata == '0);

  // R3
  rsp_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    denyValid |=> rspErr == $past(wantBusErr));

  // R5
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (denyValid && !regWe && !beFlag && !ipFlag && (wantBusErr || wantIrq))
      |=> addrWord[EA_W-1:0] == $past(denyAddr));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(denyValid && wantIrq && !regWe));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((beFlag || ipFlag) && !regWe) |=> ($stable(causeWord) && $stable(addrWord)));

  // R11
  sw_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (denyValid && regWe) |=> $stable(addrWord));
endmodule

bind blocked_err_capture blocked_err_capture_chk #(
  .ADDR_W(ADDR_W), .WID_W(WID_W), .DATA_W(DATA_W)
) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .denyValid (denyValid),
  .denyAddr  (denyAddr),
  .wantBusErr(wantBusErr),
  .wantIrq   (wantIrq),
  .regWe     (regWe),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .rspRdata  (rspRdata),
  .irq       (irq),
  .beFlag    (beFlag),
  .ipFlag    (ipFlag),
  .causeWord (causeWord),
  .addrWord  (addrWord)
);

// File: tb/blocked_err_capture_test.sv
`timescale 1ns/1ps
module blocked_err_capture_test;
  localparam int ADDR_W = 32;
  localparam int WID_W  = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              denyValid;
  logic [ADDR_W-1:2] denyAddr;
  logic [WID_W-1:0]  denyWid;
  logic              denyWrite;
  logic              wantBusErr;
  logic              wantIrq;
  logic              rspValid;
  logic              rspErr;
  logic [DATA_W-1:0] rspRdata;
  logic              irq;
  logic              regSel;
  logic              regWe;
  logic [1:0]        regWflags;
  logic [31:0]       regRdata;

  int checks = 0;
  int errors = 0;

  // model of the software-visible state
  logic        mBe, mIp, mRd, mWr;
  logic [3:0]  mWid;
  logic [29:0] mEa;

  typedef struct packed {
    logic        clrFirst;
    logic        wr;
    logic        be;
    logic        ir;
    logic [3:0]  wid;
    logic [31:0] addr;
    logic        expErr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd3,  32'h0000_1000, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd5,  32'h0000_2004, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'd2,  32'h0000_3008, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd7,  32'h0000_400C, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'd9,  32'h0000_5010, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd15, 32'hFFFF_FFFC, 1'b1}
  };

  blocked_err_capture #(.ADDR_W(ADDR_W), .WID_W(WID_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .denyValid(denyValid), .denyAddr(denyAddr),
    .denyWid(denyWid), .denyWrite(denyWrite), .wantBusErr(wantBusErr),
    .wantIrq(wantIrq), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .irq(irq), .regSel(regSel), .regWe(regWe),
    .regWflags(regWflags), .regRdata(regRdata)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] causeModel();
    logic [31:0] c = '0;
    c[3:0] = mWid; c[8] = mRd; c[9] = mWr; c[30] = mBe; c[31] = mIp;
    return c;
  endfunction

  task automatic checkRegs(input string req);
    regSel = 1'b0; #0.2;
    check({req, " cause"}, regRdata, causeModel());
    regSel = 1'b1; #0.2;
    check({req, " erraddr"}, regRdata, {2'b00, mEa});
    check({req, " irq"}, {31'd0, irq}, {31'd0, mIp});
    regSel = 1'b0;
  endtask

  task automatic swWrite(input logic sel, input logic [1:0] flags);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWflags = flags;
    @(negedge clk);
    regWe = 1'b0; regSel = 1'b0;
    if (!sel) begin
      if (!flags[0]) mBe = 1'b0;
      if (!flags[1]) mIp = 1'b0;
    end
  endtask

  // Presents one refused access; optionally with a same-cycle software write.
  task automatic access(input logic wr, input logic be, input logic ir,
                        input logic [3:0] wid, input logic [31:0] addr,
                        input logic withWrite, input logic expErr, input string req);
    @(negedge clk);
    denyValid = 1'b1; denyWrite = wr; wantBusErr = be; wantIrq = ir;
    denyWid = wid; denyAddr = addr[31:2];
    if (withWrite) begin regWe = 1'b1; regSel = 1'b0; regWflags = 2'b00; end
    @(negedge clk);
    denyValid = 1'b0; wantBusErr = 1'b0; wantIrq = 1'b0; regWe = 1'b0;
    if (withWrite) begin
      mBe = 1'b0; mIp = 1'b0;
    end else if (!(mBe || mIp) && (be || ir)) begin
      mWid = wid; mRd = ~wr; mWr = wr; mEa = addr[31:2];
      if (be) mBe = 1'b1;
      if (ir) mIp = 1'b1;
    end
    check({req, " R2 rspValid"}, {31'd0, rspValid}, 32'd1);
    check({req, " R2 rdata zero"}, rspRdata, 32'd0);
    check({req, " R3 rspErr"}, {31'd0, rspErr}, {31'd0, expErr});
    checkRegs(req);
    @(negedge clk);
    check({req, " R2 single pulse"}, {31'd0, rspValid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; denyValid = 1'b0; denyAddr = '0; denyWid = '0;
    denyWrite = 1'b0; wantBusErr = 1'b0; wantIrq = 1'b0;
    regSel = 1'b0; regWe = 1'b0; regWflags = 2'b11;
    mBe = 0; mIp = 0; mRd = 0; mWr = 0; mWid = '0; mEa = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkRegs("R1 reset");
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);

    // Table: R4 R5 R6 R7 R8 R9 R10 in sequence
    foreach (VEC[i]) begin
      if (VEC[i].clrFirst) swWrite(1'b0, 2'b00);
      access(VEC[i].wr, VEC[i].be, VEC[i].ir, VEC[i].wid, VEC[i].addr,
             1'b0, VEC[i].expErr, $sformatf("vec%0d R4-cap", i));
    end

    // R10: writing ones never sets, erraddr writes ignored
    swWrite(1'b0, 2'b00);
    checkRegs("R10 cleared");
    swWrite(1'b0, 2'b11);
    checkRegs("R10 ones no set");
    swWrite(1'b1, 2'b00);
    checkRegs("R10 addr write ignored");

    // R8: partial clear keeps the lock
    access(1'b0, 1'b1, 1'b1, 4'd6, 32'h0000_6000, 1'b0, 1'b1, "R8 arm");
    swWrite(1'b0, 2'b10);              // clears BE only, IP stays
    access(1'b1, 1'b1, 1'b0, 4'd1, 32'h0000_7000, 1'b0, 1'b1, "R8 partial lock");
    swWrite(1'b0, 2'b01);              // clears IP
    checkRegs("R8 unlocked");

    // R9: unreportable access while unlocked
    access(1'b1, 1'b0, 1'b0, 4'd4, 32'h0000_8000, 1'b0, 1'b0, "R9 silent");

    // R11: same-cycle write beats violation
    access(1'b0, 1'b1, 1'b1, 4'd8, 32'h0000_9000, 1'b1, 1'b1, "R11 sw wins");
    access(1'b0, 1'b0, 1'b1, 4'd10, 32'h0000_A000, 1'b0, 1'b0, "R11 then capture");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule